// File: doc/BRIEF.md
# Banked Nibble Calendar Clock Registers

This block is the register front end of a calendar clock. A narrow parallel bus reaches sixteen 4-bit locations. Location 0xF is a control register that answers in every bank. Its two top bits choose which bank the other fifteen locations decode to. Bank 0 holds the running time and date as decimal (BCD) digits. Bank 1 holds fifteen plain nibbles of alarm storage for a comparator outside the block. Bank 2 holds the timer control nibble. Bank 3 is empty.

The clock advances on a one-cycle `tick_sec` pulse from an external prescaler. A stop bit freezes counting so that software can rewrite the digits safely. After each advance a busy bit stays up for a fixed window of clock cycles. Software polls this bit before it samples the digits. The register bus is single-cycle with no back-pressure: a write lands at the clock edge where `bus_we` is high, and `bus_rdata` follows `bus_addr` and the current bank combinationally.

Top module: `rtc_banked_regs`

## Requirements
- R1: After reset, stop is 0, the bank is 0, busy is 0 and the digits hold 2000-01-01 00:00:00 with weekday 6. The alarm and timer nibbles reset to 0.
- R2: Address 0xF reads {bank[1:0], stop, busy} (bank in bits 3:2, stop in bit 1, busy in bit 0) from any bank. A write there sets bank and stop from bits 3:2 and bit 1. The busy bit cannot be written.
- R3: In bank 0, addresses 0x0..0xE are, in order: seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, weekday, day units, day tens, month units, month tens, year units, year tens, year hundreds, year thousands. A write stores the nibble exactly as given, and a read returns it.
- R4: When stop is 0, a tick advances the time by one second in the next cycle. Seconds and minutes wrap 59 to 00 and carry. Hours wrap 23 to 00 and advance the day and the weekday (6 wraps to 0).
- R5: The day wraps to 01 after the last day of the month: 30 for months 4, 6, 9 and 11, 31 for the other months, and 28 for month 2, or 29 when the year's last two digits are divisible by 4. Month 12 wraps to 01 and advances the 4-digit year, which wraps from 9999 to 0000.
- R6: When stop is 1, a tick changes no digit and does not raise busy.
- R7: An advancing tick makes busy read 1 for exactly BUSY_CYCLES cycles, counted from the cycle after the tick, and then 0.
- R8: In bank 1, addresses 0x0..0xE store and read back nibbles, and writes there leave the time digits unchanged.
- R9: In bank 2, address 0xE stores bits 1:0 (enable, flag) and reads bits 3:2 as 0. All other bank-2 addresses and all bank-3 addresses other than 0xF read 0 and ignore writes.
- R10: When a tick and a write fall in the same cycle, the whole time advances and the written bank-0 digit then takes the written value. A control write in the tick cycle does not affect that tick: the tick obeys the stop value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_sec | input | 1 | One-cycle pulse, once per second |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for bus_addr in the current bank |

## Verification
A second tick and a bus write can land on the same clock edge. The bench provokes this by raising `tick_sec` and `bus_we` together. It does this once on a seconds digit while the seconds are at 58 and at 59, so the carry into the minutes is visible. It also does it once with a control write that sets stop. The bench judges the result from its own model: it advances the time, then overlays the written digit. For the stop case it expects the tick to count, and the next tick to do nothing.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;

  typedef logic [3:0] nib_t;

  localparam int TIME_DIGITS = 15;

  typedef enum logic [1:0] {
    BANK_TIME  = 2'd0,
    BANK_ALARM = 2'd1,
    BANK_TIMER = 2'd2,
    BANK_SPARE = 2'd3
  } bank_e;

  localparam nib_t CTL_ADDR = 4'hF;
  localparam nib_t TMR_ADDR = 4'hE;

  // digit positions inside the time bank
  localparam int D_SEC_U = 0;
  localparam int D_SEC_T = 1;
  localparam int D_MIN_U = 2;
  localparam int D_MIN_T = 3;
  localparam int D_HR_U  = 4;
  localparam int D_HR_T  = 5;
  localparam int D_DOW   = 6;
  localparam int D_DAY_U = 7;
  localparam int D_DAY_T = 8;
  localparam int D_MON_U = 9;
  localparam int D_MON_T = 10;
  localparam int D_YR_U  = 11;
  localparam int D_YR_T  = 12;
  localparam int D_YR_H  = 13;
  localparam int D_YR_K  = 14;

  typedef struct packed {
    nib_t tens;
    nib_t units;
    logic wrap;
  } pair_t;

  // one BCD step of a two-digit field that runs first..last
  function automatic pair_t bcd_pair_step(nib_t u, nib_t t, nib_t last_u, nib_t last_t,
                                          nib_t first_u, nib_t first_t);
    pair_t r;
    r.wrap = 1'b0;
    if (u == last_u && t == last_t) begin
      r.units = first_u;
      r.tens  = first_t;
      r.wrap  = 1'b1;
    end else if (u == 4'd9) begin
      r.units = 4'd0;
      r.tens  = t + 4'd1;
    end else begin
      r.units = u + 4'd1;
      r.tens  = t;
    end
    return r;
  endfunction

  // final day of the month as two BCD digits {tens, units}
  function automatic logic [7:0] last_day_bcd(nib_t mon_u, nib_t mon_t, nib_t yr_u, nib_t yr_t);
    logic [7:0] mon_b;
    logic [7:0] yr_b;
    mon_b = {4'd0, mon_t} * 8'd10 + {4'd0, mon_u};
    yr_b  = {4'd0, yr_t} * 8'd10 + {4'd0, yr_u};
    case (mon_b)
      8'd2:                    return (yr_b[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'h30;
      default:                 return 8'h31;
    endcase
  endfunction

  function automatic nib_t reset_digit(int idx);
    case (idx)
      D_DOW:   return 4'd6;
      D_DAY_U: return 4'd1;
      D_MON_U: return 4'd1;
      D_YR_K:  return 4'd2;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_regs_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     advance,
  input  logic                     wr_en,
  input  nib_t                     wr_idx,
  input  nib_t                     wr_data,
  output logic [TIME_DIGITS*4-1:0] digits_flat
);

  nib_t       cur_q [TIME_DIGITS];
  nib_t       nxt   [TIME_DIGITS];
  pair_t      s_p, m_p, h_p, d_p, mo_p;
  logic [7:0] last_d;
  logic       cy;

  always_comb begin
    nxt    = cur_q;
    last_d = last_day_bcd(cur_q[D_MON_U], cur_q[D_MON_T], cur_q[D_YR_U], cur_q[D_YR_T]);
    s_p    = bcd_pair_step(cur_q[D_SEC_U], cur_q[D_SEC_T], 4'd9, 4'd5, 4'd0, 4'd0);
    m_p    = bcd_pair_step(cur_q[D_MIN_U], cur_q[D_MIN_T], 4'd9, 4'd5, 4'd0, 4'd0);
    h_p    = bcd_pair_step(cur_q[D_HR_U], cur_q[D_HR_T], 4'd3, 4'd2, 4'd0, 4'd0);
    d_p    = bcd_pair_step(cur_q[D_DAY_U], cur_q[D_DAY_T], last_d[3:0], last_d[7:4], 4'd1, 4'd0);
    mo_p   = bcd_pair_step(cur_q[D_MON_U], cur_q[D_MON_T], 4'd2, 4'd1, 4'd1, 4'd0);
    cy     = 1'b0;
    if (advance) begin
      nxt[D_SEC_U] = s_p.units;
      nxt[D_SEC_T] = s_p.tens;
      if (s_p.wrap) begin
        nxt[D_MIN_U] = m_p.units;
        nxt[D_MIN_T] = m_p.tens;
        if (m_p.wrap) begin
          nxt[D_HR_U] = h_p.units;
          nxt[D_HR_T] = h_p.tens;
          if (h_p.wrap) begin
            nxt[D_DOW]   = (cur_q[D_DOW] == 4'd6) ? 4'd0 : cur_q[D_DOW] + 4'd1;
            nxt[D_DAY_U] = d_p.units;
            nxt[D_DAY_T] = d_p.tens;
            if (d_p.wrap) begin
              nxt[D_MON_U] = mo_p.units;
              nxt[D_MON_T] = mo_p.tens;
              if (mo_p.wrap) begin
                cy = 1'b1;
                for (int k = D_YR_U; k <= D_YR_K; k++) begin
                  if (cy) begin
                    if (cur_q[k] == 4'd9) begin
                      nxt[k] = 4'd0;
                    end else begin
                      nxt[k] = cur_q[k] + 4'd1;
                      cy     = 1'b0;
                    end
                  end
                end
              end
            end
          end
        end
      end
    end
    // a bus write overlays the advanced value of its own digit
    if (wr_en && wr_idx < 4'(TIME_DIGITS)) nxt[wr_idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TIME_DIGITS; i++) cur_q[i] <= reset_digit(i);
    end else begin
      cur_q <= nxt;
    end
  end

  for (genvar g = 0; g < TIME_DIGITS; g++) begin : g_flat
    assign digits_flat[g*4 +: 4] = cur_q[g];
  end

  // R6: no tick and no write leaves every digit alone
  p_digits_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !wr_en) |=> $stable(digits_flat));

  // R4: seconds 59 wrap to 00
  p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wr_en && digits_flat[3:0] == 4'd9 && digits_flat[7:4] == 4'd5)
    |=> (digits_flat[7:0] == 8'h00));

  // R10: a written digit holds the written value even in a tick cycle
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < 4'(TIME_DIGITS))
    |=> (digits_flat[{$past(wr_idx), 2'b00} +: 4] == $past(wr_data)));

endmodule

// File: rtl/rtc_busy_timer.sv
module rtc_busy_timer #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R7: busy rises the cycle after an advance
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R7: the window closes after its last count
  p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt_q == CW'(1)) |=> !busy);

  // R6: without a start, an idle timer stays idle
  p_busy_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !busy) |=> !busy);

endmodule

// File: rtl/rtc_nibble_store.sv
module rtc_nibble_store
  import rtc_regs_pkg::*;
#(
  parameter int ENTRIES = 15,
  parameter int AW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  nib_t          wdata,
  input  logic [AW-1:0] raddr,
  output nib_t          rdata
);

  nib_t mem_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (we && int'(waddr) < ENTRIES) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = (int'(raddr) < ENTRIES) ? mem_q[raddr] : '0;

  // R8: a stored nibble reads back on the next cycle
  p_store_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(waddr) < ENTRIES && raddr == waddr)
    |=> ($stable(raddr) |-> rdata == $past(wdata)));

endmodule

// File: rtl/rtc_banked_regs.sv
module rtc_banked_regs
  import rtc_regs_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_sec,
  input  logic       bus_we,
  input  logic [3:0] bus_addr,
  input  logic [3:0] bus_wdata,
  output logic [3:0] bus_rdata
);

  bank_e                    bank_q;
  logic                     stop_q;
  logic [1:0]               tmr_q;
  logic                     busy;
  logic [TIME_DIGITS*4-1:0] time_flat;
  nib_t                     alarm_rd;
  logic                     ctl_hit;
  logic                     advance;
  logic                     time_we;
  logic                     alarm_we;
  logic                     tmr_we;

  assign ctl_hit  = (bus_addr == CTL_ADDR);
  assign advance  = tick_sec && !stop_q;
  assign time_we  = bus_we && !ctl_hit && bank_q == BANK_TIME;
  assign alarm_we = bus_we && !ctl_hit && bank_q == BANK_ALARM;
  assign tmr_we   = bus_we && bank_q == BANK_TIMER && bus_addr == TMR_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= BANK_TIME;
      stop_q <= 1'b0;
      tmr_q  <= 2'b00;
    end else begin
      if (bus_we && ctl_hit) begin
        stop_q <= bus_wdata[1];
        bank_q <= bank_e'(bus_wdata[3:2]);
      end
      if (tmr_we) tmr_q <= bus_wdata[1:0];
    end
  end

  rtc_calendar u_cal (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (advance),
    .wr_en       (time_we),
    .wr_idx      (bus_addr),
    .wr_data     (bus_wdata),
    .digits_flat (time_flat)
  );

  rtc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (advance),
    .busy  (busy)
  );

  rtc_nibble_store #(.ENTRIES(TIME_DIGITS), .AW(4)) u_alarm (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (alarm_we),
    .waddr (bus_addr),
    .wdata (bus_wdata),
    .raddr (bus_addr),
    .rdata (alarm_rd)
  );

  always_comb begin
    bus_rdata = 4'd0;
    if (ctl_hit) begin
      bus_rdata = {2'(bank_q), stop_q, busy};
    end else begin
      case (bank_q)
        BANK_TIME:  bus_rdata = time_flat[{bus_addr, 2'b00} +: 4];
        BANK_ALARM: bus_rdata = alarm_rd;
        BANK_TIMER: bus_rdata = (bus_addr == TMR_ADDR) ? {2'b00, tmr_q} : 4'd0;
        default:    bus_rdata = 4'd0;
      endcase
    end
  end

  // R2: the bank follows a control write
  p_bank_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ctl_hit) |=> (2'(bank_q) == $past(bus_wdata[3:2])));

  // R6: with stop set, only bus writes move the digits
  p_stop_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !time_we) |=> $stable(time_flat));

  // R9: the spare bank reads zero
  p_spare_bank_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q == BANK_SPARE && !ctl_hit) |-> (bus_rdata == 4'd0));

  // R8: writes to other banks leave the time digits alone
  p_other_bank_no_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !ctl_hit && bank_q != BANK_TIME && !advance) |=> $stable(time_flat));

endmodule

// File: tb/rtc_banked_regs_tb.sv
`timescale 1ns/1ps
module rtc_banked_regs_tb;

  localparam int BUSY_CYCLES = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_sec = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [3:0] bus_wdata = 4'd0;
  logic [3:0] bus_rdata;

  int   errors = 0;
  int   checks = 0;
  int   m_sec, m_min, m_hr, m_dow, m_day, m_mon, m_yr;
  logic m_stop = 1'b0;

  always #4 clk = ~clk;

  rtc_banked_regs #(.BUSY_CYCLES(BUSY_CYCLES)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_sec  (tick_sec),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0; m_dow = (m_dow + 1) % 7; m_day++;
          if (m_day > dim(m_mon, m_yr)) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_yr = (m_yr + 1) % 10000;
            end
          end
        end
      end
    end
  endtask

  function automatic logic [3:0] nib(int i);
    case (i)
      0:  return 4'(m_sec % 10);
      1:  return 4'(m_sec / 10);
      2:  return 4'(m_min % 10);
      3:  return 4'(m_min / 10);
      4:  return 4'(m_hr % 10);
      5:  return 4'(m_hr / 10);
      6:  return 4'(m_dow);
      7:  return 4'(m_day % 10);
      8:  return 4'(m_day / 10);
      9:  return 4'(m_mon % 10);
      10: return 4'(m_mon / 10);
      11: return 4'(m_yr % 10);
      12: return 4'((m_yr / 10) % 10);
      13: return 4'((m_yr / 100) % 10);
      default: return 4'(m_yr / 1000);
    endcase
  endfunction

  function automatic logic [59:0] model_vec();
    logic [59:0] v;
    for (int i = 0; i < 15; i++) v[i*4 +: 4] = nib(i);
    return v;
  endfunction

  task automatic chk(string tag, logic ok, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [3:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [3:0] v);
    @(negedge clk);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic rd_now(logic [3:0] a, output logic [3:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic set_ctl(logic [1:0] bank, logic stop);
    wr(4'hF, {bank, stop, 1'b0});
    m_stop = stop;
  endtask

  task automatic read_time(output logic [59:0] v);
    logic [3:0] n;
    set_ctl(2'd0, m_stop);
    for (int i = 0; i < 15; i++) begin
      rd(4'(i), n);
      v[i*4 +: 4] = n;
    end
  endtask

  task automatic cmp_time(string tag);
    logic [59:0] v;
    read_time(v);
    chk(tag, v === model_vec(), {4'd0, v}, {4'd0, model_vec()});
  endtask

  task automatic load_time(int y, int mo, int d, int dw, int h, int mi, int s);
    m_yr = y; m_mon = mo; m_day = d; m_dow = dw; m_hr = h; m_min = mi; m_sec = s;
    set_ctl(2'd0, 1'b1);
    for (int i = 0; i < 15; i++) wr(4'(i), nib(i));
    set_ctl(2'd0, 1'b0);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick_sec = 1'b1;
    @(negedge clk);
    tick_sec = 1'b0;
    if (!m_stop) model_step();
  endtask

  task automatic tick_with_write(logic [3:0] a, logic [3:0] d);
    @(negedge clk);
    tick_sec = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    tick_sec = 1'b0; bus_we = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0]  n;
    logic [59:0] v;
    logic [59:0] pat;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'hF, n);
    chk("R1 control after reset", n === 4'h0, {60'd0, n}, 64'h0);
    m_yr = 2000; m_mon = 1; m_day = 1; m_dow = 6; m_hr = 0; m_min = 0; m_sec = 0;
    cmp_time("R1 time after reset");
    set_ctl(2'd1, 1'b0);
    rd(4'h0, n);
    chk("R1 alarm nibble after reset", n === 4'h0, {60'd0, n}, 64'h0);
    set_ctl(2'd2, 1'b0);
    rd(4'hE, n);
    chk("R1 timer nibble after reset", n === 4'h0, {60'd0, n}, 64'h0);

    // R3 verbatim digit storage
    set_ctl(2'd0, 1'b1);
    for (int i = 0; i < 15; i++) begin
      pat[i*4 +: 4] = 4'(i) ^ 4'hA;
      wr(4'(i), 4'(i) ^ 4'hA);
    end
    read_time(v);
    chk("R3 digit write/readback", v === pat, {4'd0, v}, {4'd0, pat});

    // R4 R5 directed carries
    load_time(2023, 12, 31, 0, 23, 59, 59);
    do_tick();
    cmp_time("R4 R5 new year carry");
    load_time(2024, 2, 28, 3, 23, 59, 59);
    do_tick();
    cmp_time("R5 leap february 29");
    load_time(2023, 2, 28, 2, 23, 59, 59);
    do_tick();
    cmp_time("R5 common february to march");
    load_time(2024, 4, 30, 2, 23, 59, 59);
    do_tick();
    cmp_time("R5 thirty day month");
    load_time(9999, 12, 31, 5, 23, 59, 59);
    do_tick();
    cmp_time("R5 year 9999 wrap");
    load_time(2010, 7, 14, 6, 12, 59, 58);
    do_tick();
    do_tick();
    cmp_time("R4 minute and hour carry, weekday hold");

    // R7 busy window
    do_tick();
    rd_now(4'hF, n);
    chk("R7 busy first cycle", n[0] === 1'b1, {63'd0, n[0]}, 64'd1);
    for (int i = 1; i < BUSY_CYCLES; i++) begin
      rd(4'hF, n);
      chk("R7 busy inside window", n[0] === 1'b1, {63'd0, n[0]}, 64'd1);
    end
    rd(4'hF, n);
    chk("R7 busy after window", n[0] === 1'b0, {63'd0, n[0]}, 64'd0);

    // R6 stop freezes time and busy
    set_ctl(2'd0, 1'b1);
    do_tick();
    rd_now(4'hF, n);
    chk("R6 no busy while stopped", n === 4'b0010, {60'd0, n}, 64'h2);
    do_tick();
    do_tick();
    cmp_time("R6 digits frozen while stopped");
    set_ctl(2'd0, 1'b0);
    do_tick();
    cmp_time("R6 counting resumes");

    // R2 control access
    wr(4'hF, 4'b0001);
    rd(4'hF, n);
    chk("R2 busy bit not writable", n === 4'h0, {60'd0, n}, 64'h0);
    set_ctl(2'd3, 1'b0);
    rd(4'hF, n);
    chk("R2 control read in bank 3", n === 4'hC, {60'd0, n}, 64'hC);

    // R8 R9 bank routing
    set_ctl(2'd1, 1'b0);
    wr(4'h3, 4'hA);
    wr(4'hE, 4'h5);
    rd(4'h3, n);
    chk("R8 alarm nibble 3", n === 4'hA, {60'd0, n}, 64'hA);
    rd(4'hE, n);
    chk("R8 alarm nibble 14", n === 4'h5, {60'd0, n}, 64'h5);
    set_ctl(2'd2, 1'b0);
    wr(4'hE, 4'hF);
    rd(4'hE, n);
    chk("R9 timer control keeps two bits", n === 4'h3, {60'd0, n}, 64'h3);
    wr(4'h5, 4'h9);
    rd(4'h5, n);
    chk("R9 unused timer-bank address", n === 4'h0, {60'd0, n}, 64'h0);
    set_ctl(2'd3, 1'b0);
    wr(4'h2, 4'h7);
    rd(4'h2, n);
    chk("R9 spare bank reads zero", n === 4'h0, {60'd0, n}, 64'h0);
    cmp_time("R8 R9 time untouched by other banks");
    set_ctl(2'd1, 1'b0);
    rd(4'h3, n);
    chk("R8 alarm nibble kept", n === 4'hA, {60'd0, n}, 64'hA);

    // R10 tick and digit write in the same cycle
    load_time(2021, 5, 10, 1, 0, 0, 58);
    tick_with_write(4'h0, 4'h7);
    model_step();
    m_sec = 57;
    cmp_time("R10 tick with seconds write, no carry");
    load_time(2021, 5, 10, 1, 0, 0, 59);
    tick_with_write(4'h0, 4'h7);
    model_step();
    m_sec = 7;
    cmp_time("R10 tick with seconds write, minute carry");

    // R10 stop written in the tick cycle: the tick still counts
    load_time(2022, 8, 1, 1, 10, 20, 30);
    tick_with_write(4'hF, 4'b0010);
    model_step();
    m_stop = 1'b1;
    rd_now(4'hF, n);
    chk("R10 stop written in tick cycle", n === 4'b0011, {60'd0, n}, 64'h3);
    do_tick();
    set_ctl(2'd0, 1'b1);
    cmp_time("R10 tick counted once, next ignored");
    set_ctl(2'd0, 1'b0);

    // R4 R5 random dates near carries
    for (int it = 0; it < 25; it++) begin
      int y, mo, d, h, mi, s, dw, nt;
      y  = int'($urandom_range(0, 9999));
      mo = int'($urandom_range(1, 12));
      d  = ($urandom_range(0, 1) == 1) ? dim(mo, y) : int'($urandom_range(1, dim(mo, y)));
      h  = ($urandom_range(0, 1) == 1) ? 23 : int'($urandom_range(0, 23));
      mi = ($urandom_range(0, 1) == 1) ? 59 : int'($urandom_range(0, 59));
      s  = int'($urandom_range(50, 59));
      dw = int'($urandom_range(0, 6));
      nt = int'($urandom_range(1, 12));
      load_time(y, mo, d, dw, h, mi, s);
      for (int k = 0; k < nt; k++) do_tick();
      cmp_time("R4 R5 random advance");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule